// File: doc/BRIEF.md
# Buffered IR Data Pulse Generator

This block shapes the data waveform of an infrared remote transmitter. A free-running counter measures out each data cycle, and the single output pin is held at its active level from the first count of a cycle up to a programmable count. The cycle length and the active width come from two length registers. The active level can be flipped. Two interrupt flags mark the end of the active pulse and the end of the cycle. Carrier generation, modulation and clock prescaling are handled outside the block.

Software reaches the block through a synchronous register port. A write is taken on a clock edge when `reg_wen` is high. A read is combinational on `reg_addr`. The map is: address 0 is control, 1 is the data length, 2 is the pulse length and 3 is status. When buffering is on and the counter is running, a new length waits in a pending register and is copied into the working register at the next cycle wrap. A busy bit is visible for each length until that copy happens, so a period in progress is never cut short.

Top module: `irdp_gen`

## Requirements
- R1: While running, the counter starts a cycle at 0, counts up by one per clock, and wraps to 0 on the clock after it reaches the working data length D. Each cycle therefore lasts D+1 clocks.
- R2: The output is at its active level at count 0 and stays there while the count is less than or equal to the working pulse length P. It is inactive for the rest of the cycle.
- R3: The active level is high when control bit 1 (invert) is 0 and low when it is 1. While the counter is stopped, the output sits at the inactive level.
- R4: A write to address 1 (data length) or address 2 (pulse length) is accepted only while control bit 0 (enable) is 1. Otherwise the stored value does not change. Reading either address returns the last accepted value.
- R5: When control bit 2 (buffer enable) is 1 and the counter is running, an accepted length write raises a busy bit: status bit 9 for the data length, status bit 8 for the pulse length. The new value takes effect only at the next wrap, and busy then clears. A data-length write that arrives while status bit 9 is 1 is ignored.
- R6: When buffering is off, or the counter is idle, an accepted length write takes effect at once and the busy bits stay 0.
- R7: Status bit 10 reads 1 while the counter runs. Setting control bit 3 (run) with enable at 1 starts counting from 0 one clock later. Clearing run, or clearing enable, stops the counter on the next clock.
- R8: Status bit 0 is set at the last active count of a cycle and status bit 1 is set at each wrap. Writing 1 to a status bit clears it. `irq` is high when (bit 0 and control bit 5) or (bit 1 and control bit 6).
- R9: Writing 1 to control bit 4 (soft reset) stops the counter, clears the run bit, both flags and both busy bits, and keeps the length values. Control bit 4 reads back as 0.
- R10: After `rst_n`, all registers read 0, the output is low and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data, combinational on reg_addr |
| data_out | output | 1 | Data waveform pin |
| irq | output | 1 | Interrupt request |

## Verification
The bench compares the pin cycle by cycle against waveforms it builds itself. It covers a plain duty setting, an inverted setting with a one-count pulse, and a buffered period change made mid-cycle.

Several faults show up directly in the waveform:
- A design that applies a buffered length at once would shorten the first period.
- A design that still accepts data-length writes while busy would adopt the wrong second period.
- A design that compares with strictly-less-than would lose one clock per cycle.

Other checks go after the control and status bits:
- They check that writes are ignored while the block is disabled.
- They check that the inactive level is held while stopped, in both polarities.
- They check the per-flag clearing and the masking of the interrupt.
- They check that a soft reset wipes flags and running state but keeps the lengths. A design that clears the wrong flag or drops the lengths fails these reads.

// File: rtl/irdp_pkg.sv
package irdp_pkg;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_DLEN = 2'd1,
    A_PLEN = 2'd2,
    A_STAT = 2'd3
  } addr_e;

  // control bit positions
  localparam int C_EN        = 0;
  localparam int C_INV       = 1;
  localparam int C_BUF       = 2;
  localparam int C_RUN       = 3;
  localparam int C_SRST      = 4;
  localparam int C_IE_PULSE  = 5;
  localparam int C_IE_PERIOD = 6;

  // status bit positions
  localparam int S_PULSE  = 0;
  localparam int S_PERIOD = 1;
  localparam int S_PBUSY  = 8;
  localparam int S_DBUSY  = 9;
  localparam int S_RUN    = 10;

  localparam int NUM_LEN = 2;
  localparam int LEN_D   = 0;
  localparam int LEN_P   = 1;

  typedef struct packed {
    logic en;
    logic inv;
    logic bufen;
    logic run;
    logic ie_pulse;
    logic ie_period;
  } ctrl_t;

endpackage

// File: rtl/irdp_lenbuf.sv
module irdp_lenbuf #(
  parameter int W          = 16,
  parameter bit BLOCK_BUSY = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         srst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         buffered,
  input  logic         xfer,
  output logic [W-1:0] work,
  output logic [W-1:0] shadow,
  output logic         busy
);

  logic accept;
  assign accept = wr && !(BLOCK_BUSY && busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work   <= '0;
      shadow <= '0;
      busy   <= 1'b0;
    end else begin
      if (accept) begin
        shadow <= wdata;
        if (buffered) begin
          busy <= 1'b1;
        end else begin
          work <= wdata;
          busy <= 1'b0;
        end
      end else if (busy && (xfer || !buffered)) begin
        work <= shadow;
        busy <= 1'b0;
      end
      if (srst) busy <= 1'b0;
    end
  end

  // R5
  hold_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && buffered && !xfer) |=> $stable(work));

  // R6
  no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !buffered |=> !busy);

  generate
    if (BLOCK_BUSY) begin : g_block
      // R5
      busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr) |=> $stable(shadow));
    end
  endgenerate

endmodule

// File: rtl/irdp_core.sv
module irdp_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic             run_req,
  input  logic             inv,
  input  logic [CNT_W-1:0] dlen_w,
  input  logic [CNT_W-1:0] plen_w,
  output logic [CNT_W-1:0] cnt,
  output logic             running,
  output logic             wrap,
  output logic             pulse_end,
  output logic             data_out
);

  function automatic logic f_wrap(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] len);
    return c >= len;
  endfunction

  function automatic logic f_active(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] len);
    return c <= len;
  endfunction

  logic active;

  assign wrap      = running && f_wrap(cnt, dlen_w);
  assign pulse_end = running && (cnt == plen_w);
  assign active    = running && f_active(cnt, plen_w);
  assign data_out  = active ^ inv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (srst || !run_req) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (!running) begin
      running <= 1'b1;
      cnt     <= '0;
    end else if (wrap) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R1
  wrap_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && run_req && !srst) |=> (running && cnt == '0));

  // R7
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_req && !running && !srst) |=> (running && cnt == '0));

  // R7
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_req |=> !running);

  // R2
  first_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cnt == '0) |-> (data_out != inv));

endmodule

// File: rtl/irdp_regs.sv
module irdp_regs
  import irdp_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wen,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic          evt_pulse,
  input  logic          evt_period,
  input  logic          running,
  input  logic          dbusy,
  input  logic          pbusy,
  input  logic [DW-1:0] dlen_rd,
  input  logic [DW-1:0] plen_rd,
  output logic [DW-1:0] rdata,
  output ctrl_t         ctrl,
  output logic          srst,
  output logic          wr_dlen,
  output logic          wr_plen,
  output logic          irq
);

  logic [1:0] flags;
  logic [1:0] clr;
  logic [1:0] set;
  logic       ctrl_wr;

  assign ctrl_wr = wen && (addr == A_CTRL);
  assign srst    = ctrl_wr && wdata[C_SRST];
  assign wr_dlen = wen && (addr == A_DLEN) && ctrl.en;
  assign wr_plen = wen && (addr == A_PLEN) && ctrl.en;
  assign clr     = (wen && addr == A_STAT) ? {wdata[S_PERIOD], wdata[S_PULSE]} : 2'b00;
  assign set     = {evt_period, evt_pulse};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (ctrl_wr) begin
      ctrl.en        <= wdata[C_EN];
      ctrl.inv       <= wdata[C_INV];
      ctrl.bufen     <= wdata[C_BUF];
      ctrl.run       <= wdata[C_RUN] & ~wdata[C_SRST];
      ctrl.ie_pulse  <= wdata[C_IE_PULSE];
      ctrl.ie_period <= wdata[C_IE_PERIOD];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flags <= 2'b00;
    else if (srst) flags <= 2'b00;
    else           flags <= (flags & ~clr) | set;
  end

  assign irq = (flags[0] && ctrl.ie_pulse) || (flags[1] && ctrl.ie_period);

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_CTRL: begin
        rdata[C_EN]        = ctrl.en;
        rdata[C_INV]       = ctrl.inv;
        rdata[C_BUF]       = ctrl.bufen;
        rdata[C_RUN]       = ctrl.run;
        rdata[C_IE_PULSE]  = ctrl.ie_pulse;
        rdata[C_IE_PERIOD] = ctrl.ie_period;
      end
      A_DLEN: rdata = dlen_rd;
      A_PLEN: rdata = plen_rd;
      A_STAT: begin
        rdata[S_PULSE]  = flags[0];
        rdata[S_PERIOD] = flags[1];
        rdata[S_PBUSY]  = pbusy;
        rdata[S_DBUSY]  = dbusy;
        rdata[S_RUN]    = running;
      end
      default: rdata = '0;
    endcase
  end

  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_period && !srst) |=> flags[1]);

  // R8
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr[0] && !evt_pulse && !srst) |=> !flags[0]);

  // R9
  srst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (flags == 2'b00 && !ctrl.run));

endmodule

// File: rtl/irdp_gen.sv
module irdp_gen
  import irdp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wen,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             data_out,
  output logic             irq
);

  ctrl_t            ctrl;
  logic             srst;
  logic             running;
  logic             wrap;
  logic             pulse_end;
  logic [CNT_W-1:0] cnt;
  logic             run_req;

  logic             lb_wr     [NUM_LEN];
  logic [CNT_W-1:0] lb_work   [NUM_LEN];
  logic [CNT_W-1:0] lb_shadow [NUM_LEN];
  logic             lb_busy   [NUM_LEN];

  assign run_req = ctrl.run && ctrl.en;

  irdp_regs #(.DW(CNT_W)) regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wen        (reg_wen),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .evt_pulse  (pulse_end),
    .evt_period (wrap),
    .running    (running),
    .dbusy      (lb_busy[LEN_D]),
    .pbusy      (lb_busy[LEN_P]),
    .dlen_rd    (lb_shadow[LEN_D]),
    .plen_rd    (lb_shadow[LEN_P]),
    .rdata      (reg_rdata),
    .ctrl       (ctrl),
    .srst       (srst),
    .wr_dlen    (lb_wr[LEN_D]),
    .wr_plen    (lb_wr[LEN_P]),
    .irq        (irq)
  );

  generate
    for (genvar g = 0; g < NUM_LEN; g++) begin : g_len
      irdp_lenbuf #(.W(CNT_W), .BLOCK_BUSY(g == LEN_D)) lb_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .srst     (srst),
        .wr       (lb_wr[g]),
        .wdata    (reg_wdata),
        .buffered (ctrl.bufen && running),
        .xfer     (wrap),
        .work     (lb_work[g]),
        .shadow   (lb_shadow[g]),
        .busy     (lb_busy[g])
      );
    end
  endgenerate

  irdp_core #(.CNT_W(CNT_W)) core_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .srst      (srst),
    .run_req   (run_req),
    .inv       (ctrl.inv),
    .dlen_w    (lb_work[LEN_D]),
    .plen_w    (lb_work[LEN_P]),
    .cnt       (cnt),
    .running   (running),
    .wrap      (wrap),
    .pulse_end (pulse_end),
    .data_out  (data_out)
  );

  // R4
  wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && reg_addr == A_DLEN && !ctrl.en) |=> $stable(lb_shadow[LEN_D]));

  // R3
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (data_out == ctrl.inv));

endmodule

// File: tb/irdp_gen_tb_top.sv
module irdp_gen_tb_top;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wen = 1'b0;
  logic [1:0]   reg_addr = 2'd0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic         data_out;
  logic         irq;

  int    checks = 0;
  int    errors = 0;
  logic  exp_q[$];
  string sb_tag = "R1";
  bit    done = 1'b0;

  always #10 clk = ~clk;

  irdp_gen #(.CNT_W(W)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wen   (reg_wen),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .data_out  (data_out),
    .irq       (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // driver: expected pin level per clock of each period
  task automatic push_wave(input int d, input int p, input bit inv, input int periods);
    for (int n = 0; n < periods; n++)
      for (int k = 0; k <= d; k++)
        exp_q.push_back(((k <= p) ? 1'b1 : 1'b0) ^ inv);
  endtask

  task automatic drain();
    wait (exp_q.size() == 0);
    @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        logic e;
        e = exp_q.pop_front();
        chk(sb_tag, 32'(data_out), 32'(e));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk("R10 out", 32'(data_out), 0);
    chk("R10 irq", 32'(irq), 0);
    rd(2'd3, v); chk("R10 status", 32'(v), 0);
    rd(2'd1, v); chk("R10 dlen", 32'(v), 0);
    rd(2'd0, v); chk("R10 ctrl", 32'(v), 0);

    // R4 writes ignored while disabled
    wr(2'd1, 16'd5);
    rd(2'd1, v); chk("R4 disabled write", 32'(v), 0);

    // R1 R2 basic waveform
    wr(2'd0, 16'h0001);
    wr(2'd1, 16'd5);
    wr(2'd2, 16'd2);
    rd(2'd1, v); chk("R4 enabled write", 32'(v), 5);
    wr(2'd0, 16'h0029);
    sb_tag = "R1/R2 d5 p2";
    push_wave(5, 2, 1'b0, 3);
    drain();
    rd(2'd3, v);
    chk("R7 running", 32'(v[10]), 1);
    chk("R8 flags set", 32'(v[1:0]), 3);
    chk("R8 irq pulse", 32'(irq), 1);

    // R7 stop, R3 idle level
    wr(2'd0, 16'h0021);
    @(negedge clk);
    chk("R3 idle low", 32'(data_out), 0);
    rd(2'd3, v); chk("R7 stopped", 32'(v[10]), 0);
    wr(2'd3, 16'h0001);
    rd(2'd3, v); chk("R8 w1c pulse", 32'(v[1:0]), 2);
    chk("R8 irq masked", 32'(irq), 0);
    wr(2'd0, 16'h0041);
    chk("R8 irq period", 32'(irq), 1);
    wr(2'd3, 16'h0002);
    chk("R8 irq cleared", 32'(irq), 0);

    // R3 inverted
    wr(2'd0, 16'h0003);
    chk("R3 idle inverted", 32'(data_out), 1);
    wr(2'd1, 16'd3);
    wr(2'd2, 16'd0);
    wr(2'd0, 16'h000B);
    sb_tag = "R3 inverted d3 p0";
    push_wave(3, 0, 1'b1, 2);
    drain();
    wr(2'd0, 16'h0003);
    @(negedge clk);

    // R5 buffered change mid-cycle
    wr(2'd0, 16'h0005);
    wr(2'd1, 16'd7);
    wr(2'd2, 16'd3);
    wr(2'd0, 16'h000D);
    sb_tag = "R5 buffered";
    push_wave(7, 3, 1'b0, 1);
    push_wave(4, 3, 1'b0, 2);
    wr(2'd1, 16'd4);
    rd(2'd3, v); chk("R5 dlen busy", 32'(v[9]), 1);
    wr(2'd1, 16'd2);
    rd(2'd1, v); chk("R5 write while busy", 32'(v), 4);
    drain();
    rd(2'd3, v); chk("R5 busy cleared", 32'(v[9]), 0);

    // R6 unbuffered
    wr(2'd0, 16'h0009);
    wr(2'd1, 16'd6);
    rd(2'd3, v);
    chk("R6 no busy", 32'(v[9]), 0);
    chk("R7 still running", 32'(v[10]), 1);
    chk("R8 flags before srst", 32'(v[1:0] != 0), 1);

    // R9 soft reset
    wr(2'd0, 16'h0019);
    rd(2'd3, v); chk("R9 status cleared", 32'(v), 0);
    rd(2'd0, v); chk("R9 run cleared", 32'(v[4:3]), 0);
    rd(2'd1, v); chk("R9 length kept", 32'(v), 6);
    @(negedge clk);
    chk("R3 idle after srst", 32'(data_out), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule